// File: doc/BRIEF.md
# Register-Controlled Serial Flash Manual Port

This block gives software direct, byte-by-byte control of a serial flash. It decodes a 256-byte register window on a simple 32-bit request/ready bus. Software lowers and raises the flash select line through one-shot command bits, records the lane width it would like to use, and keeps a set of mode flags that it can read back. Bytes reach the flash through a data register and come back through another. Underneath sits a single-lane mode-0 shift engine that drives the serial clock, the output data line and the active-low select, and samples the input data line.

A write to the transmit register sends one, two or four bytes, depending on the access size. The least significant byte goes first. A byte-wide read of the receive register itself starts one exchange and returns the byte that was captured. While an exchange is in progress the bus ready signal stays low, so each bus access finishes only after its serial work is done. The serial clock period is a parameter, `CLK_DIV` system clocks, which must be even and at least 2.

Top module: `spi_manual_ctrl`

## Requirements
- R1: After reset the select output is high, the serial clock is low, `lane_req` is 0, and the mode register (offset 0x04) reads 0.
- R2: A write to offset 0x00 with bit 3 set drives `spi_cs_n` low, and with bit 4 set drives it high; bit 4 wins if both are set. Only such writes change `spi_cs_n`, and bits 3 and 4 always read back as 0.
- R3: A write to offset 0x00 with any of bits [2:0] set (single, dual, quad) stores those three bits on `lane_req` and in read-back bits [2:0]. Data still moves only on `spi_mosi`/`spi_miso`.
- R4: A write to offset 0x18 sends one byte for `bus_size`=0, two bytes for 1 and four bytes for 2 or 3, starting with `bus_wdata[7:0]` and moving upward.
- R5: Each byte goes out most significant bit first in mode 0. The serial clock idles low and has a period of `CLK_DIV` system clocks, `spi_mosi` is stable while the clock is high, and `spi_miso` is sampled on the rising edge.
- R6: Offset 0x04 stores and returns bits 0 to 9, 12 and 13 of the written value. Bits 10, 11 and 14 to 31 read as 0.
- R7: A read of offset 0x1C with `bus_size`=0 makes one 8-bit exchange that sends 0x00 and returns the received byte in `bus_rdata[7:0]`.
- R8: A read of offset 0x1C with `bus_size` not 0 completes at once, returns 0 and makes no serial clock edges.
- R9: Accesses to offsets 0x0C, 0x10, 0x28, 0x2C, 0x30, 0x34 (and any other unused offset) complete at once, read 0 and change no output or register.
- R10: Register accesses assert `bus_ready` in the cycle they are presented. A transfer of N bytes holds `bus_ready` low for 8*`CLK_DIV`*N+1 cycles, and `bus_ready` is never high while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wr | input | 1 | Write request, held until ready |
| bus_rd | input | 1 | Read request, held until ready |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Access completes on the clock edge where this is high |
| lane_req | output | 3 | Last requested lane width flags (single, dual, quad) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hard case is the receive path. The captured byte exists only inside the block until a byte-wide read of the receive register finishes, and the same read must also put out a 0x00 byte. The bench loads a byte into its flash model, which shifts it out on falling clock edges. It then issues that read and compares the returned data with the model's byte, while the scoreboard matches the 0x00 seen on the output line. The bench also counts serial clock edges across halfword reads and writes to the inactive offsets, which shows that these accesses start no transfer.

// File: rtl/spi_manual_ctrl.sv
module spi_manual_ctrl #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic [2:0]  lane_req,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_MODE = 8'h04;
  localparam logic [7:0] A_TX   = 8'h18;
  localparam logic [7:0] A_RX   = 8'h1C;
  localparam logic [13:0] MODE_MASK = 14'h33FF;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DONE} st_t;

  st_t          st;
  logic [13:0]  mode_q;
  logic [7:0]   sh_q, rx_q;
  logic [31:0]  word_q;
  logic [1:0]   left_q;
  logic [2:0]   bit_q;
  logic [HW-1:0] half_q;
  logic         rd_op_q;

  wire hit_tx = bus_wr && bus_addr == A_TX;
  wire hit_rx = bus_rd && !bus_wr && bus_addr == A_RX && bus_size == 2'd0;
  wire idle   = st == S_IDLE;
  wire start  = idle && (hit_tx || hit_rx);
  wire reg_wr = idle && bus_wr && !hit_tx;

  assign bus_ready = (st == S_DONE) || (idle && (bus_wr || bus_rd) && !(hit_tx || hit_rx));
  assign spi_mosi  = sh_q[7];

  always_comb begin
    bus_rdata = '0;
    if (st == S_DONE) begin
      if (rd_op_q) bus_rdata = {24'd0, rx_q};
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {29'd0, lane_req};
        A_MODE:  bus_rdata = {18'd0, mode_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      lane_req <= '0;
      mode_q   <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      word_q   <= '0;
      left_q   <= '0;
      bit_q    <= '0;
      half_q   <= '0;
      rd_op_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_SHIFT;
            spi_sclk <= 1'b0;
            half_q  <= '0;
            bit_q   <= '0;
            rd_op_q <= hit_rx;
            if (hit_tx) begin
              sh_q   <= bus_wdata[7:0];
              word_q <= bus_wdata;
              left_q <= (bus_size == 2'd0) ? 2'd0 : (bus_size == 2'd1) ? 2'd1 : 2'd3;
            end else begin
              sh_q   <= '0;
              word_q <= '0;
              left_q <= '0;
            end
          end else if (reg_wr) begin
            if (bus_addr == A_CTRL) begin
              if (|bus_wdata[2:0]) lane_req <= bus_wdata[2:0];
              if (bus_wdata[4])      spi_cs_n <= 1'b1;
              else if (bus_wdata[3]) spi_cs_n <= 1'b0;
            end else if (bus_addr == A_MODE) begin
              mode_q <= bus_wdata[13:0] & MODE_MASK;
            end
          end
        end
        S_SHIFT: begin
          if (half_q == HALF_LAST) begin
            half_q <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rx_q     <= {rx_q[6:0], spi_miso};
            end else begin
              spi_sclk <= 1'b0;
              if (bit_q == 3'd7) begin
                bit_q <= '0;
                if (left_q == 2'd0) begin
                  st <= S_DONE;
                end else begin
                  left_q <= left_q - 2'd1;
                  word_q <= word_q >> 8;
                  sh_q   <= word_q[15:8];
                end
              end else begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
              end
            end
          end else begin
            half_q <= half_q + HW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_manual_ctrl_chk.sv
module spi_manual_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_ready,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_cs_n
);
  p_cs_by_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> $past(bus_wr && bus_ready && bus_addr == 8'h00));

  p_cs_release_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && bus_addr == 8'h00 && bus_wdata[4]) |=> spi_cs_n);

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !bus_ready);

  p_mode_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_ready && bus_addr == 8'h04) |-> (bus_rdata[11:10] == 2'b00 && bus_rdata[31:14] == 18'd0));
endmodule

bind spi_manual_ctrl spi_manual_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/sim_spi_manual_ctrl.sv
module sim_spi_manual_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [2:0]  lane_req;
  logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rcv = '0;
  int bcnt = 0;
  int rises = 0;
  logic [7:0] slave_sh = '0;
  realtime last_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign spi_miso = slave_sh[7];

  spi_manual_ctrl #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .lane_req(lane_req), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge spi_sclk) begin
    rcv = {rcv[6:0], spi_mosi};
    if (bcnt != 0) check("R5 sclk period", int'(($realtime - last_rise) / CLK_PERIOD), DIV);
    last_rise = $realtime;
    bcnt++;
    rises++;
    if (bcnt == 8) begin
      bcnt = 0;
      if (exp_q.size() == 0) check("R4 unexpected byte", {24'd0, rcv}, 32'hFFFF_FFFF);
      else check("R4/R5 mosi byte", {24'd0, rcv}, {24'd0, exp_q.pop_front()});
    end
  end

  always @(negedge spi_sclk) slave_sh = {slave_sh[6:0], 1'b0};

  task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
    #1;
    waits = 0;
    while (!bus_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic send(input logic [1:0] sz, input logic [31:0] d, input int nbytes);
    logic [31:0] r;
    int w;
    for (int i = 0; i < nbytes; i++) exp_q.push_back(d[8*i +: 8]);
    access(1'b1, 8'h18, sz, d, r, w);
    check("R10 transfer ready latency", w, 8*DIV*nbytes + 1);
    check("R4 all bytes sent", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w, r0;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1'b1;

    check("R1 cs_n after reset", spi_cs_n, 1);
    check("R1 sclk after reset", spi_sclk, 0);
    check("R1 lane_req after reset", lane_req, 0);
    access(1'b0, 8'h04, 2'd2, 0, r, w);
    check("R1 mode after reset", r, 0);
    check("R10 register read no wait", w, 0);

    access(1'b1, 8'h00, 2'd2, 32'h8, r, w);
    check("R2 cs asserted", spi_cs_n, 0);
    access(1'b0, 8'h00, 2'd2, 0, r, w);
    check("R2 strobes read zero", r[4:3], 0);

    send(2'd0, 32'h0000_005A, 1);
    send(2'd1, 32'h0000_1234, 2);
    send(2'd2, 32'hDEAD_BEEF, 4);
    send(2'd3, 32'h0102_8081, 4);

    slave_sh = 8'hA5;
    exp_q.push_back(8'h00);
    r0 = rises;
    access(1'b0, 8'h1C, 2'd0, 0, r, w);
    check("R7 received byte", r, 32'hA5);
    check("R7 eight clocks", rises - r0, 8);
    check("R7 sent 0x00", exp_q.size(), 0);
    slave_sh = 8'h3C;
    exp_q.push_back(8'h00);
    access(1'b0, 8'h1C, 2'd0, 0, r, w);
    check("R7 second byte", r, 32'h3C);

    r0 = rises;
    access(1'b0, 8'h1C, 2'd1, 0, r, w);
    check("R8 halfword read zero", r, 0);
    check("R8 no wait", w, 0);
    access(1'b0, 8'h1C, 2'd2, 0, r, w);
    check("R8 word read zero", r, 0);
    check("R8 no clocks", rises - r0, 0);

    access(1'b1, 8'h04, 2'd2, 32'hFFFF_FFFF, r, w);
    access(1'b0, 8'h04, 2'd2, 0, r, w);
    check("R6 mode readback ones", r, 32'h33FF);
    access(1'b1, 8'h04, 2'd2, 32'h0000_2015, r, w);
    access(1'b0, 8'h04, 2'd2, 0, r, w);
    check("R6 mode readback pattern", r, 32'h2015);

    access(1'b1, 8'h00, 2'd2, 32'h4, r, w);
    check("R3 quad request flagged", lane_req, 3'd4);
    check("R3 cs unchanged", spi_cs_n, 0);
    access(1'b0, 8'h00, 2'd2, 0, r, w);
    check("R3 request readback", r, 4);
    access(1'b1, 8'h00, 2'd2, 32'h2, r, w);
    check("R3 dual request flagged", lane_req, 3'd2);

    r0 = rises;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h0C : (i == 1) ? 8'h10 : (i == 2) ? 8'h28 :
          (i == 3) ? 8'h2C : (i == 4) ? 8'h30 : 8'h34;
      access(1'b1, a, 2'd2, 32'hFFFF_FFFF, r, w);
      check("R9 write no wait", w, 0);
      access(1'b0, a, 2'd2, 0, r, w);
      check("R9 read zero", r, 0);
    end
    check("R9 no clocks", rises - r0, 0);
    check("R9 cs unchanged", spi_cs_n, 0);
    check("R9 lane unchanged", lane_req, 3'd2);
    access(1'b0, 8'h04, 2'd2, 0, r, w);
    check("R9 mode unchanged", r, 32'h2015);

    access(1'b1, 8'h00, 2'd2, 32'h18, r, w);
    check("R2 release wins", spi_cs_n, 1);
    access(1'b1, 8'h00, 2'd2, 32'h8, r, w);
    access(1'b1, 8'h00, 2'd2, 32'h10, r, w);
    check("R2 cs released", spi_cs_n, 1);

    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule